// File: doc/BRIEF.md
# Transmit Byte Queue with Fill Threshold

This block holds bytes waiting to be sent. A serial-interface byte port loads it, and the transmit datapath drains it. The queue stores up to 64 bytes and presents the oldest stored byte on its read port at all times. A read request moves to the next byte. A 4-bit threshold code sets a fill level. A flag reports when the byte count is at or above that level, so the loader knows when it may add more data.

Reading an empty queue is an error. The block records it in an underflow flag, and the flag stays set until a flush. Writing to a full queue is not guarded. The write lands on the oldest entry and the count wraps, so stored data is lost and no error is raised. A flush empties the queue and clears the error.

Control is a three-state occupancy machine:

- **Q_EMPTY**: the count is 0.
- **Q_PARTIAL**: the count is between 1 and 63.
- **Q_FULL**: the count is 64.

Its transitions are:

- **load**: Q_EMPTY to Q_PARTIAL on a write.
- **top-up**: Q_PARTIAL to Q_FULL when the count reaches 64.
- **drain**: Q_PARTIAL to Q_EMPTY when the count reaches 0.
- **release**: Q_FULL to Q_PARTIAL on a read without a write.
- **wrap**: Q_FULL to Q_PARTIAL on a write without a read, leaving the count at 1.
- **flush**: any state to Q_EMPTY.

Top module: `tx_fifo_thr`

## Requirements
- R1: After reset, `fill_count` is 0, `empty` is 1, `underflow_err` is 0 and `thr_hit` is 0.
- R2: Bytes come out on `rd_data` in the order they were written. `rd_data` always shows the oldest stored byte. Each write adds one to `fill_count`.
- R3: A read of a non-empty queue removes one byte and lowers `fill_count` by one. A read and a write in the same cycle on a non-empty queue leave `fill_count` unchanged.
- R4: `empty` is 1 exactly when `fill_count` is 0.
- R5: For threshold code n (0 to 15), the level is 61 − 4n bytes. For example, code 0 gives 61, code 3 gives 49 and code 6 gives 37. `thr_hit` is 1 when `fill_count` is at or above the level. It is a combinational function of the count and the code.
- R6: A read while `fill_count` is 0 sets `underflow_err`. The count stays at 0 and no stored byte is skipped. A write in that same cycle is still accepted.
- R7: Once set, `underflow_err` stays 1 through any later reads and writes until a flush.
- R8: A write while `fill_count` is 64 with no read raises no error. It overwrites the oldest byte and leaves `fill_count` at 1. The byte just written becomes the only one that can be read.
- R9: `flush` clears the count, the read and write positions, and `underflow_err` at the next clock edge. It takes priority over a read or write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the queue and clear the error |
| wr_en | input | 1 | Write request from the byte port |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read request from the transmit datapath |
| rd_data | output | 8 | Oldest stored byte |
| thr_code | input | 4 | Threshold code; level = 61 − 4·code |
| fill_count | output | 7 | Number of stored bytes, 0 to 64 |
| empty | output | 1 | High when no byte is stored |
| thr_hit | output | 1 | High when the count is at or above the level |
| underflow_err | output | 1 | Sticky read-while-empty error |

## Verification
The clocked assertions check the following on every cycle:

- An empty read sets the error.
- The error holds until a flush, and a flush clears the count and the error.
- A simultaneous read and write keeps the count.
- A write into a full queue wraps the count to 1.
- The threshold flag is always high when the queue is full.

Other behaviours can only be shown by the bench scenarios against its scoreboard queue:

- byte ordering across the storage wrap;
- the exact threshold level for each code;
- the survivor byte after an overwrite;
- no byte being skipped after an underflow.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txq_thresh.sv
module txq_thresh #(
    parameter int CW        = 7,
    parameter int CODE_W    = 4,
    parameter int TOP_LEVEL = 61,
    parameter int STEP      = 4,
    parameter int DEPTH     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    int level;

    always_comb begin
        level = TOP_LEVEL - STEP * int'(code);
        hit   = int'(count) >= level;
    end

    // R5
    full_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> hit);
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          store_we,
    output logic          empty,
    output logic          underflow
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    occ_state_t    state, state_nxt;
    logic [CW-1:0] count_nxt;
    logic [AW-1:0] wr_ptr_nxt, rd_ptr_nxt;
    logic          ufl_nxt;
    logic          rd_take;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= Q_EMPTY;
            count     <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            underflow <= 1'b0;
        end else begin
            state     <= state_nxt;
            count     <= count_nxt;
            wr_ptr    <= wr_ptr_nxt;
            rd_ptr    <= rd_ptr_nxt;
            underflow <= ufl_nxt;
        end
    end

    // next-state process
    always_comb begin
        rd_take   = rd_en && (state != Q_EMPTY);
        count_nxt = count;
        unique case (state)
            Q_EMPTY:   count_nxt = wr_en ? ONE_CNT : '0;
            Q_PARTIAL: begin
                if (wr_en && !rd_take)      count_nxt = count + ONE_CNT;
                else if (!wr_en && rd_take) count_nxt = count - ONE_CNT;
            end
            Q_FULL: begin
                if (wr_en && !rd_take)      count_nxt = ONE_CNT;
                else if (!wr_en && rd_take) count_nxt = FULL_CNT - ONE_CNT;
            end
            default:   count_nxt = '0;
        endcase
        wr_ptr_nxt = wr_ptr + (wr_en   ? AW'(1) : AW'(0));
        rd_ptr_nxt = rd_ptr + (rd_take ? AW'(1) : AW'(0));
        ufl_nxt    = underflow || (rd_en && state == Q_EMPTY);
        if (flush) begin
            count_nxt  = '0;
            wr_ptr_nxt = '0;
            rd_ptr_nxt = '0;
            ufl_nxt    = 1'b0;
        end
        if (count_nxt == '0)           state_nxt = Q_EMPTY;
        else if (count_nxt == FULL_CNT) state_nxt = Q_FULL;
        else                           state_nxt = Q_PARTIAL;
    end

    // output process
    always_comb begin
        store_we = wr_en && !flush;
        empty    = (state == Q_EMPTY);
    end

    // R6
    ufl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count == '0 && !flush) |=> underflow);
    // R7
    ufl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush) |=> underflow);
    // R9
    flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !underflow));
    // R3
    rdwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && !flush && count != '0) |=> $stable(count));
    // R8
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush && count == FULL_CNT) |=> (count == ONE_CNT));
endmodule

// File: rtl/tx_fifo_thr.sv
module tx_fifo_thr #(
    parameter int DW        = 8,
    parameter int DEPTH     = 64,
    parameter int CODE_W    = 4,
    parameter int TOP_LEVEL = 61,
    parameter int STEP      = 4,
    parameter int AW        = $clog2(DEPTH),
    parameter int CW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    input  logic [CODE_W-1:0] thr_code,
    output logic [CW-1:0]     fill_count,
    output logic              empty,
    output logic              thr_hit,
    output logic              underflow_err
);
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          store_we;

    txq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (fill_count),
        .store_we  (store_we),
        .empty     (empty),
        .underflow (underflow_err)
    );

    txq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    txq_thresh #(.CW(CW), .CODE_W(CODE_W), .TOP_LEVEL(TOP_LEVEL),
                 .STEP(STEP), .DEPTH(DEPTH)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (fill_count),
        .code  (thr_code),
        .hit   (thr_hit)
    );
endmodule

// File: tb/sim_tx_fifo_thr.sv
module sim_tx_fifo_thr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] thr_code = '0;
    logic [6:0] fill_count;
    logic       empty, thr_hit, underflow_err;

    int   nchk = 0, nfail = 0;
    logic [7:0] sb[$];
    bit   m_ufl = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_fifo_thr u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .thr_code(thr_code), .fill_count(fill_count),
        .empty(empty), .thr_hit(thr_hit), .underflow_err(underflow_err)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: updates the scoreboard and compares read data before each edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (flush) begin
                sb.delete();
                m_ufl = 1'b0;
            end else begin
                if (rd_en) begin
                    if (sb.size() > 0) chk("R2 rd_data", int'(rd_data), int'(sb.pop_front()));
                    else m_ufl = 1'b1;
                end
                if (wr_en) begin
                    if (sb.size() == 64) sb.delete();
                    sb.push_back(wr_data);
                end
            end
        end
    end

    function automatic int exp_hit(int cnt, int code);
        return (cnt >= 61 - 4 * code) ? 1 : 0;
    endfunction

    task automatic check_state(string tag);
        chk({tag, " fill_count"}, int'(fill_count), sb.size());
        chk("R4 empty", int'(empty), (sb.size() == 0) ? 1 : 0);
        chk({tag, " underflow"}, int'(underflow_err), int'(m_ufl));
        chk("R5 thr_hit", int'(thr_hit), exp_hit(sb.size(), int'(thr_code)));
    endtask

    // driver: one clock cycle of stimulus, then a state check after the edge
    task automatic cyc(bit f, bit w, logic [7:0] d, bit r, string tag);
        flush = f; wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        #1;
        flush = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        check_state(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 fill_count", int'(fill_count), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 underflow", int'(underflow_err), 0);
        chk("R1 thr_hit", int'(thr_hit), 0);
        rst_n = 1'b1;
        #1;

        // R2 writes raise the count
        for (int i = 0; i < 5; i++) cyc(0, 1, 8'h10 + 8'(i), 0, "R2");
        // R3 reads drain in order
        cyc(0, 0, 8'h00, 1, "R3");
        cyc(0, 0, 8'h00, 1, "R3");
        // R3 read and write together keep the count
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h40 + 8'(i), 1, "R3");
        while (sb.size() > 0) cyc(0, 0, 8'h00, 1, "R3");

        // R6 read while empty
        cyc(0, 0, 8'h00, 1, "R6");
        cyc(0, 0, 8'h00, 1, "R6");
        // R6 with a write in the same cycle
        cyc(0, 1, 8'h77, 1, "R6");
        // R7 error persists through traffic; no byte skipped
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'h80 + 8'(i), 0, "R7");
        for (int i = 0; i < 4; i++) cyc(0, 0, 8'h00, 1, "R7");
        cyc(0, 0, 8'h00, 0, "R7");

        // R9 flush clears error
        cyc(1, 0, 8'h00, 0, "R9");

        // R5 fill to 64, rotating codes
        for (int i = 0; i < 64; i++) begin
            thr_code = 4'(i % 16);
            cyc(0, 1, 8'(i * 3 + 1), 0, "R5");
        end
        // R5 sweep all codes at several counts
        for (int c = 0; c < 16; c++) begin
            thr_code = 4'(c);
            cyc(0, 0, 8'h00, 0, "R5");
        end
        for (int k = 0; k < 4; k++) cyc(0, 0, 8'h00, 1, "R5");
        for (int c = 0; c < 16; c++) begin
            thr_code = 4'(c);
            cyc(0, 0, 8'h00, 0, "R5");
        end
        for (int k = 0; k < 3; k++) cyc(0, 1, 8'hC0 + 8'(k), 0, "R5");
        for (int c = 0; c < 8; c++) begin
            thr_code = 4'(c);
            cyc(0, 0, 8'h00, 0, "R5");
        end
        cyc(0, 1, 8'hC3, 0, "R5");
        chk("R8 full before overwrite", int'(fill_count), 64);

        // R3 read and write together while full
        cyc(0, 1, 8'hD0, 1, "R3");
        // R8 write while full
        cyc(0, 1, 8'hA5, 0, "R8");
        chk("R8 count after overwrite", int'(fill_count), 1);
        chk("R8 no error", int'(underflow_err), 0);
        chk("R8 survivor byte", int'(rd_data), 8'hA5);
        cyc(0, 0, 8'h00, 1, "R8");

        // R9 flush beats a same-cycle read and write
        for (int i = 0; i < 6; i++) cyc(0, 1, 8'hE0 + 8'(i), 0, "R9");
        cyc(0, 0, 8'h00, 1, "R9");
        cyc(0, 0, 8'h00, 1, "R9");
        cyc(1, 1, 8'hEE, 1, "R9");
        chk("R9 count zero", int'(fill_count), 0);
        cyc(0, 1, 8'h5A, 0, "R9");
        chk("R9 position reset data", int'(rd_data), 8'h5A);
        cyc(0, 0, 8'h00, 1, "R9");

        finish_run();
    end
endmodule